// File: doc/BRIEF.md
# Mark/Space Tone Discriminator

This block turns a digitized, already band-limited receive signal from a low-speed frequency-shift-keyed link into a received data bit. Each sample that arrives with its valid strobe is first hard-limited: only its polarity against a reference level is kept, so the amplitude of the line signal cannot push the decision toward either tone. The resulting ±1 stream drives two second-order resonators in parallel. One resonator is tuned to the mark tone of the current receive pair and the other to the space tone.

The magnitude of each resonator output is smoothed by a leaky integrator whose decay is a right shift. A final register compares the two smoothed energies. It drives the data bit high when the mark energy is larger and low when the space energy is larger. When the two energies are equal the bit keeps its previous value. A single select input picks which tone pair is received. A station that placed the call listens on the upper pair, and a station that answered listens on the lower pair. The block assumes a sample rate of 9600 samples per second. Its resonator coefficients are fixed-point constants for that rate.

Top module: `fsk_discrim`

## Requirements
- R1: Each valid sample is reduced to +1 when it is greater than or equal to the reference level (parameter, default 0) and to -1 otherwise. As a result, the decision does not depend on signal amplitude or on the sign of the overall gain.
- R2: Two resonant paths run in parallel on the limited stream, one tuned to the mark tone and one to the space tone. Each has the form y[n] = x[n] + a1·y[n-1] − a2·y[n-2], with coefficients in Q14.
- R3: Each path's output magnitude, shifted right by a parameter, feeds a leaky integrator e ← e − (e >> DECAY) + rect. A zero input never makes the energy grow.
- R4: The data bit `rx_bit` becomes 1 when the smoothed mark energy exceeds the smoothed space energy, and 0 when the space energy exceeds the mark energy.
- R5: When the two smoothed energies are equal, `rx_bit` keeps its previous value.
- R6: With `orig_sel` = 1 the mark tone is 2225 Hz and the space tone is 2025 Hz. With `orig_sel` = 0 the mark tone is 1270 Hz and the space tone is 1070 Hz (sample rate 9600 Hz).
- R7: Cycles without `smp_valid` change no filter state, no energy and no output once the pipeline has drained (4 cycles after the last valid sample).
- R8: A synchronous active-high reset clears `rx_bit`, all resonator state and both energies to zero.
- R9: Phase-continuous data that alternates between mark and space is tracked bit by bit, with the output settled at the end of each 256-sample bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Strobe: `smp_data` holds a new sample |
| smp_data | input | SMP_W (16) | Two's-complement receive sample |
| orig_sel | input | 1 | 1: receive the upper tone pair; 0: receive the lower pair |
| rx_bit | output | 1 | Recovered data, 1 = mark |

## Verification
The bench drives very small, very large and sign-inverted tones. A design that scaled its decision by amplitude, or that kept magnitude instead of sign at the limiter, would misread these.

Irregular gaps between valid strobes, together with long idle stretches, expose a filter or integrator that advances on cycles without data. The idle stretch right after reset, where both energies are zero, catches a comparator that resolves ties to a fixed level instead of holding.

Random bit sequences with noise, random amplitudes and switching of the tone pair show whether the mark and space coefficients were swapped or tied to the wrong role. In either case the recovered bit would come out inverted or random.

// File: rtl/fskd_pkg.sv
package fskd_pkg;

    localparam int COEF_W = 18;
    localparam int COEF_F = 14;
    localparam int ACC_W  = 32;

    typedef enum logic {ROLE_ANSWER = 1'b0, ROLE_ORIG = 1'b1} role_e;
    typedef enum logic {PATH_SPACE = 1'b0, PATH_MARK = 1'b1} path_e;

    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    typedef struct packed {
        coef_t fb1;
        coef_t fb2;
    } reso_coef_t;

    typedef struct packed {
        logic vld;
        logic pos;
    } lim_t;

    typedef struct packed {
        logic vld;
        acc_t y;
    } reso_out_t;

    // Pole radius 0.98 at 9600 samples/s; fb1 = 2r*cos(w), fb2 = r^2, both Q14.
    function automatic reso_coef_t tone_coef(role_e role, path_e path);
        reso_coef_t c;
        c.fb2 = coef_t'(15735);
        case ({role, path})
            {ROLE_ANSWER, PATH_SPACE}: c.fb1 = coef_t'(24555); // 1070 Hz
            {ROLE_ANSWER, PATH_MARK }: c.fb1 = coef_t'(21643); // 1270 Hz
            {ROLE_ORIG,   PATH_SPACE}: c.fb1 = coef_t'(7803);  // 2025 Hz
            default:                   c.fb1 = coef_t'(3670);  // 2225 Hz
        endcase
        return c;
    endfunction

    function automatic logic [ACC_W-1:0] mag(acc_t v);
        return v[ACC_W-1] ? ACC_W'(-v) : ACC_W'(v);
    endfunction

endpackage

// File: rtl/fskd_limiter.sv
module fskd_limiter
    import fskd_pkg::*;
#(
    parameter int SMP_W   = 16,
    parameter int LIM_REF = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [SMP_W-1:0] in_smp,
    output lim_t             q
);
    localparam logic signed [SMP_W-1:0] REF_S = SMP_W'(LIM_REF);

    logic signed [SMP_W-1:0] smp_s;
    assign smp_s = in_smp;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.vld <= in_vld;
            if (in_vld) begin
                q.pos <= (smp_s >= REF_S);
            end
        end
    end

    // R1: one limited symbol per valid sample, one cycle later
    p_lim_strobe_r1: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> q.vld);
    p_lim_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> (!q.vld && $stable(q.pos)));
endmodule

// File: rtl/fskd_resonator.sv
module fskd_resonator
    import fskd_pkg::*;
#(
    parameter path_e PATH = PATH_SPACE
) (
    input  logic      clk,
    input  logic      rst,
    input  lim_t      lin,
    input  role_e     role,
    output reso_out_t q
);
    localparam int PROD_W = ACC_W + COEF_W;
    localparam acc_t ONE  = acc_t'(1) <<< COEF_F;

    reso_coef_t cf;
    coef_t      k1, k2;
    acc_t       y1, y2, x_in, y_new;
    logic signed [PROD_W-1:0] p1, p2;
    logic       vld_q;

    always_comb begin
        cf    = tone_coef(role, PATH);
        k1    = cf.fb1;
        k2    = cf.fb2;
        x_in  = lin.pos ? ONE : -ONE;
        p1    = PROD_W'(k1) * PROD_W'(y1);
        p2    = PROD_W'(k2) * PROD_W'(y2);
        y_new = x_in + ACC_W'(p1 >>> COEF_F) - ACC_W'(p2 >>> COEF_F);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            y1    <= '0;
            y2    <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= lin.vld;
            if (lin.vld) begin
                y2 <= y1;
                y1 <= y_new;
            end
        end
    end

    assign q = '{vld: vld_q, y: y1};

    // R2: the delay line shifts by exactly one sample per valid symbol
    p_res_shift_r2: assert property (@(posedge clk) disable iff (rst)
        lin.vld |=> (y2 == $past(y1)));
    // R7: no symbol, no state change
    p_res_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !lin.vld |=> ($stable(y1) && $stable(y2)));
endmodule

// File: rtl/fskd_energy.sv
module fskd_energy
    import fskd_pkg::*;
#(
    parameter int DECAY   = 5,
    parameter int RECT_SH = 8,
    parameter int E_W     = ACC_W + DECAY
) (
    input  logic           clk,
    input  logic           rst,
    input  reso_out_t      din,
    output logic [E_W-1:0] e,
    output logic           e_vld
);
    logic [ACC_W-1:0] rect;
    logic [E_W-1:0]   e_next;

    always_comb begin
        rect   = mag(din.y) >> RECT_SH;
        e_next = e - (e >> DECAY) + E_W'(rect);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            e     <= '0;
            e_vld <= 1'b0;
        end else begin
            e_vld <= din.vld;
            if (din.vld) begin
                e <= e_next;
            end
        end
    end

    // R3: with nothing rectified the integrator only leaks
    p_leak_only_r3: assert property (@(posedge clk) disable iff (rst)
        (din.vld && rect == '0) |=> (e <= $past(e)));
    // R7: energy frozen between samples
    p_energy_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !din.vld |=> $stable(e));
endmodule

// File: rtl/fsk_discrim.sv
module fsk_discrim
    import fskd_pkg::*;
#(
    parameter int SMP_W   = 16,
    parameter int LIM_REF = 0,
    parameter int DECAY   = 5,
    parameter int RECT_SH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    input  logic             orig_sel,
    output logic             rx_bit
);
    localparam int E_W    = ACC_W + DECAY;
    localparam int NPATH  = 2;

    role_e     role;
    lim_t      lim;
    reso_out_t reso [NPATH];
    logic [E_W-1:0] energy [NPATH];
    logic [NPATH-1:0] e_vld;

    assign role = role_e'(orig_sel);

    fskd_limiter #(.SMP_W(SMP_W), .LIM_REF(LIM_REF)) u_lim (
        .clk    (clk),
        .rst    (rst),
        .in_vld (smp_valid),
        .in_smp (smp_data),
        .q      (lim)
    );

    for (genvar g = 0; g < NPATH; g++) begin : g_path
        fskd_resonator #(.PATH(path_e'(g))) u_res (
            .clk  (clk),
            .rst  (rst),
            .lin  (lim),
            .role (role),
            .q    (reso[g])
        );
        fskd_energy #(.DECAY(DECAY), .RECT_SH(RECT_SH), .E_W(E_W)) u_en (
            .clk   (clk),
            .rst   (rst),
            .din   (reso[g]),
            .e     (energy[g]),
            .e_vld (e_vld[g])
        );
    end

    logic [E_W-1:0] e_mark, e_space;
    logic           cmp_go;
    assign e_mark  = energy[PATH_MARK];
    assign e_space = energy[PATH_SPACE];
    assign cmp_go  = e_vld[PATH_MARK];

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_bit <= 1'b0;
        end else if (cmp_go) begin
            if (e_mark > e_space) begin
                rx_bit <= 1'b1;
            end else if (e_mark < e_space) begin
                rx_bit <= 1'b0;
            end
        end
    end

    // R4: larger mark energy drives a one, larger space energy a zero
    p_mark_wins_r4: assert property (@(posedge clk) disable iff (rst)
        (cmp_go && e_mark > e_space) |=> rx_bit);
    p_space_wins_r4: assert property (@(posedge clk) disable iff (rst)
        (cmp_go && e_mark < e_space) |=> !rx_bit);
    // R5: a tie keeps the previous decision
    p_tie_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (e_mark == e_space) |=> $stable(rx_bit));
    // R7: nothing moves through the pipeline, nothing changes at the output
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!smp_valid && !lim.vld && !reso[0].vld && !cmp_go) |=> $stable(rx_bit));
    // both paths advance in lock step
    p_paths_aligned_r2: assert property (@(posedge clk) disable iff (rst)
        e_vld[0] == e_vld[1]);
endmodule

// File: tb/sim_fsk_discrim.sv
module sim_fsk_discrim;
    localparam int    SMP_W = 16;
    localparam int    NSMP  = 256;
    localparam real   FS    = 9600.0;
    localparam real   TWO_PI = 6.283185307179586;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_valid = 1'b0;
    logic [SMP_W-1:0] smp_data = '0;
    logic orig_sel = 1'b0;
    logic rx_bit;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;
    real phase = 0.0;

    always #2 clk = ~clk;

    fsk_discrim u0 (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .orig_sel  (orig_sel),
        .rx_bit    (rx_bit)
    );

    function automatic real tone_hz(bit orig, bit mark);
        if (orig) return mark ? 2225.0 : 2025.0;
        return mark ? 1270.0 : 1070.0;
    endfunction

    task automatic check(bit got, bit exp, string req);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: rx_bit=%0b expected %0b (orig_sel=%0b)", req, got, exp, orig_sel);
        end
    endtask

    task automatic put_sample(int v);
        int c;
        c = v > 32767 ? 32767 : (v < -32768 ? -32768 : v);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = SMP_W'(c);
        @(negedge clk);
        smp_valid = 1'b0;
        repeat ($urandom_range(0, 1)) @(negedge clk);
    endtask

    // one phase-continuous bit, then a check after the pipeline drains
    task automatic send_bit(bit mark, int amp, int noise, string req);
        real f;
        int  v;
        f = tone_hz(orig_sel, mark);
        for (int i = 0; i < NSMP; i++) begin
            phase = phase + TWO_PI * f / FS;
            if (phase > TWO_PI) phase = phase - TWO_PI;
            v = $rtoi(amp * $sin(phase));
            if (noise > 0) v = v + int'($urandom_range(0, 2 * noise)) - noise;
            put_sample(v);
        end
        repeat (6) @(negedge clk);
        check(rx_bit, mark, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        bit prev;
        bit b;
        int amp;
        void'($urandom(32'd4242));

        repeat (5) @(negedge clk);
        check(rx_bit, 1'b0, "R8 reset value");
        rst = 1'b0;
        // R5/R7: both energies stay zero, the tie holds the reset value
        repeat (30) @(negedge clk);
        check(rx_bit, 1'b0, "R5 tie at zero energy");

        // R6/R4 lower pair, directed
        orig_sel = 1'b0;
        send_bit(1'b1, 3000, 0, "R6 answer mark 1270");
        send_bit(1'b0, 3000, 0, "R6 answer space 1070");
        send_bit(1'b1, 3000, 0, "R4 mark wins");
        // R1 amplitude independence: tiny and inverted signals
        send_bit(1'b0, 4, 0, "R1 tiny space");
        send_bit(1'b1, 4, 0, "R1 tiny mark");
        send_bit(1'b0, -20000, 0, "R1 inverted space");
        send_bit(1'b1, -20000, 0, "R1 inverted mark");

        // R7: idle stretch keeps the decision
        prev = rx_bit;
        repeat (60) @(negedge clk);
        check(rx_bit, prev, "R7 idle hold after mark");

        // R6 upper pair, directed
        orig_sel = 1'b1;
        send_bit(1'b0, 5000, 0, "R6 originate space 2025");
        send_bit(1'b1, 5000, 0, "R6 originate mark 2225");
        send_bit(1'b0, 5000, 500, "R6 originate space noisy");
        prev = rx_bit;
        repeat (60) @(negedge clk);
        check(rx_bit, prev, "R7 idle hold after space");

        // R9: alternating phase-continuous data in both pairs
        for (int k = 0; k < 6; k++) send_bit(k[0] == 1'b0, 8000, 800, "R9 alternating");
        orig_sel = 1'b0;
        for (int k = 0; k < 6; k++) send_bit(k[0] == 1'b1, 8000, 800, "R9 alternating");

        // constrained random: data, amplitude, noise and pair
        for (int k = 0; k < 30; k++) begin
            if ($urandom_range(0, 3) == 0) orig_sel = ~orig_sel;
            b   = 1'($urandom_range(0, 1));
            amp = int'($urandom_range(50, 20000));
            if ($urandom_range(0, 1) == 1) amp = -amp;
            send_bit(b, amp, (amp < 0 ? -amp : amp) / 4, "R2 R3 random bit");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule